// File: doc/BRIEF.md
# Serial Key Debug and Boot Unlock Gate

This block holds a device in a secured state in which debug/emulation access and booting from external sources are both refused. To open the device, a host shifts a key, one bit per clock, into a shift register through the test-access serial path. It then pulses an update strobe. On that strobe the captured value is compared with the per-device key, which is supplied on a parallel input from key storage outside this block. An exact match opens the gate. Any other value is dropped without effect.

Two outputs are driven from the lock state. One grants access to the emulation logic. The other tells boot-source selection that external sources may be used. While the gate is locked, boot is held to internal memory only. When the security-enable strap is low, the gate reports open directly after reset and needs no key. Once opened, the gate stays open until reset. The shift register is wiped on every strobe, so no key bits stay in it after a compare.

Top module: `unlk_gate`

## Requirements
- R1: After reset with security enabled (`sec_en_i`=1), both `emu_unlock_o` and `ext_boot_ok_o` are 0.
- R2: While `shift_en_i`=1 and `update_i`=0, one bit of `tdi_i` enters the key register on each rising clock edge, least significant bit first. After KEY_W shifts, the first bit shifted is key bit 0.
- R3: While both `shift_en_i` and `update_i` are 0, the key register holds its value, whatever `tdi_i` does.
- R4: When `update_i` is sampled high and the key register equals `dev_key_i`, both unlock outputs read 1 from the next clock edge on.
- R5: When `update_i` is sampled high and the key register differs from `dev_key_i`, the lock state does not change.
- R6: The key register is cleared to zero on every edge where `update_i` is high. A second strobe with no new shifting compares against zero.
- R7: Once open, the gate stays open until reset. A later strobe with a wrong key does not lock it again.
- R8: With `sec_en_i`=0, both unlock outputs are 1 from reset on, with no key shifted.
- R9: When `update_i` and `shift_en_i` are both high in the same cycle, the compare uses the register contents before that edge, and the bit on `tdi_i` is discarded.
- R10: Asserting reset (`rst_n`=0) returns an opened gate to the locked state when security is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_en_i | input | 1 | Security-enable strap; 0 leaves the gate open |
| dev_key_i | input | KEY_W | Stored per-device key |
| tdi_i | input | 1 | Serial key data |
| shift_en_i | input | 1 | Shift one bit per clock while high |
| update_i | input | 1 | Compare strobe; clears the key register |
| emu_unlock_o | output | 1 | Emulation/debug access granted |
| ext_boot_ok_o | output | 1 | External boot sources permitted |

## Verification
The bench builds the gate with KEY_W=64 and CHUNK_W=16. The full key therefore runs through four separate chunk comparators, and a single flipped bit in any chunk must still prevent opening. Keys are shifted bit-reversed, with only the top or bottom bit wrong, or as all zeros and all ones. These patterns reach the ordering and the per-chunk reduction. Directed sequences cover the strobe-clears-register corner, the shift-and-strobe collision, and a reset that locks an opened gate again.

// File: rtl/unlk_pkg.sv
package unlk_pkg;
    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_e;
endpackage

// File: rtl/key_shreg.sv
module key_shreg #(
    parameter int KEY_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en_i,
    input  logic             tdi_i,
    input  logic             update_i,
    output logic [KEY_W-1:0] key_o
);
    typedef struct packed {
        logic [KEY_W-1:0] sr;
    } sr_st_t;

    sr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (update_i) begin
            st_d.sr = '0;
        end else if (shift_en_i) begin
            st_d.sr = {tdi_i, st_q.sr[KEY_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key_o = st_q.sr;

    assert_clear_on_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        update_i |=> (key_o == '0));

    assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en_i && !update_i) |=> (key_o[KEY_W-1] == $past(tdi_i)));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en_i && !update_i) |=> $stable(key_o));
endmodule

// File: rtl/key_cmp.sv
module key_cmp #(
    parameter int KEY_W   = 64,
    parameter int CHUNK_W = 16
) (
    input  logic [KEY_W-1:0] cand_i,
    input  logic [KEY_W-1:0] ref_i,
    output logic             match_o
);
    localparam int NCHUNK = (KEY_W + CHUNK_W - 1) / CHUNK_W;
    localparam int PAD_W  = NCHUNK * CHUNK_W;

    logic [PAD_W-1:0]  cand_pad, ref_pad;
    logic [NCHUNK-1:0] chunk_eq;

    always_comb begin
        cand_pad = '0;
        ref_pad  = '0;
        cand_pad[KEY_W-1:0] = cand_i;
        ref_pad[KEY_W-1:0]  = ref_i;
    end

    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        assign chunk_eq[g] = (cand_pad[g*CHUNK_W +: CHUNK_W] == ref_pad[g*CHUNK_W +: CHUNK_W]);
    end

    assign match_o = &chunk_eq;
endmodule

// File: rtl/lock_ctl.sv
module lock_ctl
    import unlk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_en_i,
    input  logic update_i,
    input  logic match_i,
    output logic emu_unlock_o,
    output logic ext_boot_ok_o
);
    typedef struct packed {
        lock_state_e state;
    } lk_st_t;

    lk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.state == ST_LOCKED && update_i && match_i) begin
            st_d.state = ST_OPEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: ST_LOCKED};
        else        st_q <= st_d;
    end

    logic open_w;
    assign open_w        = !sec_en_i || (st_q.state == ST_OPEN);
    assign emu_unlock_o  = open_w;
    assign ext_boot_ok_o = open_w;

    assert_open_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_OPEN) |=> (st_q.state == ST_OPEN));

    assert_mismatch_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_LOCKED && !(update_i && match_i)) |=> (st_q.state == ST_LOCKED));

    assert_match_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (update_i && match_i) |=> (st_q.state == ST_OPEN));

    assert_strap_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_en_i |-> (emu_unlock_o && ext_boot_ok_o));
endmodule

// File: rtl/unlk_gate.sv
module unlk_gate #(
    parameter int KEY_W   = 64,
    parameter int CHUNK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_en_i,
    input  logic [KEY_W-1:0] dev_key_i,
    input  logic             tdi_i,
    input  logic             shift_en_i,
    input  logic             update_i,
    output logic             emu_unlock_o,
    output logic             ext_boot_ok_o
);
    logic [KEY_W-1:0] key_w;
    logic             match_w;

    key_shreg #(.KEY_W(KEY_W)) u_shreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (shift_en_i),
        .tdi_i      (tdi_i),
        .update_i   (update_i),
        .key_o      (key_w)
    );

    key_cmp #(.KEY_W(KEY_W), .CHUNK_W(CHUNK_W)) u_cmp (
        .cand_i  (key_w),
        .ref_i   (dev_key_i),
        .match_o (match_w)
    );

    lock_ctl u_lock (
        .clk           (clk),
        .rst_n         (rst_n),
        .sec_en_i      (sec_en_i),
        .update_i      (update_i),
        .match_i       (match_w),
        .emu_unlock_o  (emu_unlock_o),
        .ext_boot_ok_o (ext_boot_ok_o)
    );

    assert_outputs_agree_R1: assert property (@(posedge clk) disable iff (!rst_n)
        emu_unlock_o == ext_boot_ok_o);
endmodule

// File: tb/tb_unlk_gate.sv
module tb_unlk_gate;
    localparam int KW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_en = 1'b1;
    logic [KW-1:0] dkey = '0;
    logic          tdi = 1'b0;
    logic          sh_en = 1'b0;
    logic          upd = 1'b0;
    logic          emu, boot;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    unlk_gate #(.KEY_W(KW), .CHUNK_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .sec_en_i(sec_en), .dev_key_i(dkey),
        .tdi_i(tdi), .shift_en_i(sh_en), .update_i(upd),
        .emu_unlock_o(emu), .ext_boot_ok_o(boot)
    );

    typedef struct packed {
        logic [KW-1:0] shin;
        logic [KW-1:0] devk;
        logic          exp_open;
    } vec_t;

    localparam logic [KW-1:0] K0 = 64'hA5C3_0F1E_9B27_D46C;
    localparam logic [KW-1:0] K0_REV = 64'h362B_E4D9_78F0_C3A5;

    localparam vec_t VECS [7] = '{
        '{shin: K0,                          devk: K0,                      exp_open: 1'b1},
        '{shin: K0_REV,                      devk: K0,                      exp_open: 1'b0},
        '{shin: K0 ^ 64'h1,                  devk: K0,                      exp_open: 1'b0},
        '{shin: K0 ^ 64'h8000_0000_0000_0000, devk: K0,                     exp_open: 1'b0},
        '{shin: 64'h0,                       devk: 64'h0,                   exp_open: 1'b1},
        '{shin: 64'hFFFF_FFFF_FFFF_FFFF,     devk: 64'hFFFF_FFFF_FFFF_FFFF, exp_open: 1'b1},
        '{shin: K0 ^ 64'h0000_0100_0000_0000, devk: K0,                     exp_open: 1'b0}
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sh_en = 1'b0; upd = 1'b0; tdi = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic shift_key(input logic [KW-1:0] k);
        for (int i = 0; i < KW; i++) begin
            sh_en = 1'b1; tdi = k[i];
            @(negedge clk);
        end
        sh_en = 1'b0; tdi = 1'b0;
    endtask

    task automatic strobe();
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1", {emu, boot}, 2'b00);

        // Table walk: R2 order, R4 match, R5 mismatch
        for (int v = 0; v < 7; v++) begin
            do_reset();
            dkey = VECS[v].devk;
            shift_key(VECS[v].shin);
            check(VECS[v].exp_open ? "R4" : "R5", {emu, boot}, 2'b00);
            strobe();
            check(VECS[v].exp_open ? "R4" : "R2/R5", {emu, boot},
                  {VECS[v].exp_open, VECS[v].exp_open});
        end

        // R3: idle cycles with toggling data must not disturb the register
        do_reset();
        dkey = K0;
        shift_key(K0);
        for (int i = 0; i < 9; i++) begin
            tdi = i[0];
            @(negedge clk);
        end
        tdi = 1'b0;
        strobe();
        check("R3", {emu, boot}, 2'b11);

        // R6: a wrong compare clears the register; second strobe sees zero
        do_reset();
        dkey = ~K0;
        shift_key(K0);
        strobe();
        check("R6", {emu, boot}, 2'b00);
        dkey = K0;
        strobe();
        check("R6", {emu, boot}, 2'b00);
        dkey = 64'h0;
        strobe();
        check("R6", {emu, boot}, 2'b11);

        // R7: a later wrong key does not relock
        do_reset();
        dkey = K0;
        shift_key(K0);
        strobe();
        check("R7", {emu, boot}, 2'b11);
        shift_key(~K0);
        strobe();
        check("R7", {emu, boot}, 2'b11);

        // R10: reset relocks
        do_reset();
        check("R10", {emu, boot}, 2'b00);

        // R9: shift and strobe together, the strobe uses the old contents
        dkey = K0;
        shift_key(K0);
        sh_en = 1'b1; tdi = ~K0[0]; upd = 1'b1;
        @(negedge clk);
        sh_en = 1'b0; upd = 1'b0; tdi = 1'b0;
        check("R9", {emu, boot}, 2'b11);

        // R9: partial key then a colliding strobe must not open
        do_reset();
        dkey = K0;
        for (int i = 0; i < KW-1; i++) begin
            sh_en = 1'b1; tdi = K0[i];
            @(negedge clk);
        end
        sh_en = 1'b1; tdi = K0[KW-1]; upd = 1'b1;
        @(negedge clk);
        sh_en = 1'b0; upd = 1'b0; tdi = 1'b0;
        check("R9", {emu, boot}, 2'b00);

        // R8: strap low opens without a key
        sec_en = 1'b0;
        do_reset();
        check("R8", {emu, boot}, 2'b11);
        dkey = K0;
        shift_key(~K0);
        strobe();
        check("R8", {emu, boot}, 2'b11);
        sec_en = 1'b1;
        @(negedge clk);
        check("R1", {emu, boot}, 2'b00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule